// File: doc/BRIEF.md
# DMA Request Handshake Controller

This block is the request front end of a single external DMA channel. A peripheral asks for service on a request pin. The block synchronizes that pin, decides when a bus transaction to the peripheral is due, and starts it on a simple bus master handshake. While each access is open it holds an acknowledge line to the peripheral. The access closes when the peripheral answers with either a success response or an error response.

A one-cycle `start_i` pulse loads the transfer length and arms the channel. Two request modes are available:
- **Level mode.** The channel keeps issuing accesses for as long as the request stays high. The request is examined again after each access completes.
- **Edge mode.** Each valid edge of the request latches one pending operand. A configuration bit chooses whether the rising or the falling edge is the valid one.

The channel ends the whole transfer when the count runs out or an error is returned. It then pulses `done_o` and falls idle until the next start.

Top module: `dma_req_ctrl`

## Requirements
- R1: After `rst_ni` is asserted, `dack_o`, `bus_req_o` and `done_o` are all 0 and the channel is idle.
- R2: `dreq_i` passes through a two-flop synchronizer sampled on the rising clock edge. With `level_mode_i`=1, the armed channel issues accesses back to back for as long as the synchronized request is 1.
- R3: With `level_mode_i`=0, exactly one access is issued per valid request edge. `rise_edge_i`=1 makes a 0-to-1 transition valid and `rise_edge_i`=0 makes a 1-to-0 transition valid. The opposite transition starts no access.
- R4: In edge mode, a valid edge sets a pending request that is held until the access serving it completes. Further edges seen while the request is pending are dropped and add no access.
- R5: `bus_req_o` is a one-cycle pulse in the first cycle of each access. `dack_o` is 1 from that cycle up to and including the cycle in which `bus_ack_i` or `bus_err_i` is sampled, and it stays 1 while neither response is present.
- R6: Each access completed with `bus_ack_i` decrements the count loaded from `cnt_i`. When the count reaches zero, `done_o` is 1 for exactly one cycle, the channel goes idle, and later requests start no access until the next `start_i`.
- R7: An access answered with `bus_err_i` ends the whole transfer: `done_o` pulses for one cycle and the channel goes idle. `bus_err_i` takes priority over `bus_ack_i` when both are present.
- R8: In level mode the request is re-evaluated only after the current access completes. If the peripheral drops `dreq_i` while `dack_o` is high and the response arrives at least three cycles later, no further access is started.
- R9: A `start_i` pulse with `cnt_i`=0 pulses `done_o` for one cycle and starts no access.
- R10: `start_i` is ignored unless the channel is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle arm pulse; loads the count |
| cnt_i | input | CNT_W | Number of operands to move |
| level_mode_i | input | 1 | 1 = level-sensitive request, 0 = edge-sensitive |
| rise_edge_i | input | 1 | Edge mode: 1 = rising edge valid, 0 = falling |
| dreq_i | input | 1 | Asynchronous request from the peripheral |
| dack_o | output | 1 | Acknowledge to the peripheral during each access |
| bus_req_o | output | 1 | One-cycle start of a bus access |
| bus_ack_i | input | 1 | Access completed successfully |
| bus_err_i | input | 1 | Access completed with an error |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The main function is exercised with four kinds of request pattern:
- **Single pulses of each polarity in edge mode.** These separate the two edge selections and show whether an opposite transition is wrongly taken as a request.
- **More pulses than the programmed count.** This shows whether the channel stops at zero and stays idle.
- **Fast double pulses inside one pending window.** These reveal any queuing of requests beyond a single pending operand.
- **A held level request, once run to completion and once dropped during the acknowledge.** These separate back-to-back issue from the check made after each access.

Error responses at different positions in the transfer, and a zero count, cover the early-termination paths.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACC  = 2'd2
  } chan_st_e;
endpackage

// File: rtl/dreq_sync.sv
module dreq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dreq_i,
  output logic cur_o,
  output logic prv_o
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], dreq_i};
  end

  assign cur_o = sh_q[STAGES-1];
  assign prv_o = sh_q[STAGES];
endmodule

// File: rtl/dreq_detect.sv
module dreq_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cur_i,
  input  logic prv_i,
  input  logic level_mode_i,
  input  logic rise_edge_i,
  input  logic armed_i,
  input  logic clr_i,
  output logic go_o
);
  logic vld_edge;
  logic pend_q;

  assign vld_edge = rise_edge_i ? (cur_i & ~prv_i) : (~cur_i & prv_i);

  // clear wins: edges during the completing cycle are dropped as well
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pend_q <= 1'b0;
    else if (clr_i || !armed_i)     pend_q <= 1'b0;
    else if (vld_edge && !pend_q)   pend_q <= 1'b1;
  end

  assign go_o = level_mode_i ? cur_i : pend_q;
endmodule

// File: rtl/xfer_cnt.sv
module xfer_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             dec_i,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= val_i;
    else if (dec_i)  cnt_q <= cnt_q - ONE;
  end

  assign last_o = (cnt_q == ONE);
endmodule

// File: rtl/dma_req_ctrl.sv
module dma_req_ctrl #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             level_mode_i,
  input  logic             rise_edge_i,
  input  logic             dreq_i,
  output logic             dack_o,
  output logic             bus_req_o,
  input  logic             bus_ack_i,
  input  logic             bus_err_i,
  output logic             done_o
);
  import dma_req_pkg::*;

  chan_st_e st_q, st_d;
  logic     cur, prv, go, last;
  logic     load, ok_end, err_end, fin, zero_start;
  logic     start_q, done_q;

  dreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .dreq_i(dreq_i),
    .cur_o (cur),   .prv_o (prv)
  );

  dreq_detect u_det (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cur_i       (cur),
    .prv_i       (prv),
    .level_mode_i(level_mode_i),
    .rise_edge_i (rise_edge_i),
    .armed_i     (st_q != ST_IDLE),
    .clr_i       (fin),
    .go_o        (go)
  );

  xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .val_i (cnt_i),
    .dec_i (ok_end),
    .last_o(last)
  );

  assign load       = (st_q == ST_IDLE) && start_i;
  assign zero_start = load && (cnt_i == '0);
  assign err_end    = (st_q == ST_ACC) && bus_err_i;
  assign ok_end     = (st_q == ST_ACC) && bus_ack_i && !bus_err_i;
  assign fin        = err_end || ok_end;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (load && !zero_start) st_d = ST_WAIT;
      ST_WAIT: if (go)                  st_d = ST_ACC;
      ST_ACC: begin
        if (err_end)                    st_d = ST_IDLE;
        else if (ok_end)                st_d = last ? ST_IDLE : ST_WAIT;
      end
      default:                          st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= (st_q == ST_WAIT) && go;
      done_q  <= zero_start || err_end || (ok_end && last);
    end
  end

  assign dack_o    = (st_q == ST_ACC);
  assign bus_req_o = start_q;
  assign done_o    = done_q;
endmodule

// File: rtl/dma_req_ctrl_chk.sv
module dma_req_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic dack_o,
  input logic bus_req_o,
  input logic bus_ack_i,
  input logic bus_err_i,
  input logic done_o
);
  assert_req_in_dack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> dack_o);
  assert_dack_rise_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dack_o) |-> bus_req_o);
  assert_req_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |=> !bus_req_o);
  assert_dack_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_o && !bus_ack_i && !bus_err_i) |=> dack_o);
  assert_err_ends_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dack_o && bus_err_i) |=> (!dack_o && done_o));
  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !dack_o);
endmodule

bind dma_req_ctrl dma_req_ctrl_chk chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .dack_o   (dack_o),
  .bus_req_o(bus_req_o),
  .bus_ack_i(bus_ack_i),
  .bus_err_i(bus_err_i),
  .done_o   (done_o)
);

// File: tb/dma_req_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_req_ctrl_tb_top;
  localparam int CNT_W = 16;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [CNT_W-1:0] cnt_i = '0;
  logic             level_mode_i = 1'b0;
  logic             rise_edge_i = 1'b1;
  logic             dreq_i = 1'b0;
  logic             bus_ack_i = 1'b0;
  logic             bus_err_i = 1'b0;
  logic             dack_o, bus_req_o, done_o;

  int checks = 0;
  int fails = 0;
  int acc_cnt = 0;
  int done_cnt = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  dma_req_ctrl #(.CNT_W(CNT_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .cnt_i(cnt_i),
    .level_mode_i(level_mode_i), .rise_edge_i(rise_edge_i), .dreq_i(dreq_i),
    .dack_o(dack_o), .bus_req_o(bus_req_o), .bus_ack_i(bus_ack_i),
    .bus_err_i(bus_err_i), .done_o(done_o)
  );

  always @(negedge clk_i) if (rst_ni) begin
    if (bus_req_o) acc_cnt++;
    if (done_o)    done_cnt++;
  end

  // lvl, rise, count, request pulses, error on access k (0 none),
  // level drop on access k (0 none), expected accesses, expected done pulses
  typedef struct packed {
    bit       lvl;
    bit       rise;
    bit [7:0] cnt;
    bit [7:0] nreq;
    bit [7:0] err_k;
    bit [7:0] stop_k;
    bit [7:0] exp_acc;
    bit [7:0] exp_done;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 8'd3, 8'd3, 8'd0, 8'd0, 8'd3, 8'd1},
    '{1'b0, 1'b0, 8'd2, 8'd4, 8'd0, 8'd0, 8'd2, 8'd1},
    '{1'b0, 1'b1, 8'd4, 8'd4, 8'd2, 8'd0, 8'd2, 8'd1},
    '{1'b1, 1'b0, 8'd5, 8'd5, 8'd0, 8'd0, 8'd5, 8'd1},
    '{1'b1, 1'b0, 8'd6, 8'd6, 8'd0, 8'd3, 8'd3, 8'd0},
    '{1'b1, 1'b1, 8'd3, 8'd5, 8'd0, 8'd0, 8'd3, 8'd1},
    '{1'b0, 1'b0, 8'd1, 8'd1, 8'd1, 8'd0, 8'd1, 8'd1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    start_i = 1'b0; bus_ack_i = 1'b0; bus_err_i = 1'b0;
    cyc(2);
    rst_ni = 1'b1;
    cyc(1);
  endtask

  task automatic pulse_start(input int cnt);
    cnt_i = CNT_W'(cnt);
    start_i = 1'b1;
    cyc(1);
    start_i = 1'b0;
  endtask

  task automatic wait_dack(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 15 && !seen; i++) begin
      if (dack_o) seen = 1'b1;
      else cyc(1);
    end
  endtask

  task automatic respond(input bit err);
    cyc(2);
    if (err) bus_err_i = 1'b1; else bus_ack_i = 1'b1;
    cyc(1);
    bus_err_i = 1'b0; bus_ack_i = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int a0, d0;
    bit seen;
    do_reset();
    level_mode_i = v.lvl;
    rise_edge_i  = v.rise;
    dreq_i = (!v.lvl && !v.rise) ? 1'b1 : 1'b0;
    cyc(5);
    a0 = acc_cnt; d0 = done_cnt;
    pulse_start(int'(v.cnt));
    if (!v.lvl) begin
      for (int k = 1; k <= int'(v.nreq); k++) begin
        dreq_i = v.rise;
        wait_dack(seen);
        if (seen) respond(int'(v.err_k) == k);
        dreq_i = ~v.rise;
        cyc(4);
      end
    end else begin
      dreq_i = 1'b1;
      for (int k = 1; k <= int'(v.nreq); k++) begin
        wait_dack(seen);
        if (seen) begin
          if (int'(v.stop_k) == k) begin
            dreq_i = 1'b0;
            cyc(1);
          end
          respond(int'(v.err_k) == k);
        end
      end
      dreq_i = 1'b0;
      cyc(6);
    end
    cyc(4);
    // R2 R3 R6 R7 R8: access count per vector
    check(acc_cnt - a0 == int'(v.exp_acc),
          $sformatf("R2/R3/R6/R7/R8 vec%0d accesses", idx), acc_cnt - a0, int'(v.exp_acc));
    check(done_cnt - d0 == int'(v.exp_done),
          $sformatf("R6/R7 vec%0d done pulses", idx), done_cnt - d0, int'(v.exp_done));
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int a0, d0;
    bit seen;
    bit any_dack;
    // R1 reset state
    cyc(2);
    check(dack_o == 1'b0, "R1 dack_o", int'(dack_o), 0);
    check(bus_req_o == 1'b0, "R1 bus_req_o", int'(bus_req_o), 0);
    check(done_o == 1'b0, "R1 done_o", int'(done_o), 0);
    rst_ni = 1'b1;
    cyc(2);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R3: opposite polarity edge starts nothing
    do_reset();
    level_mode_i = 1'b0; rise_edge_i = 1'b1; dreq_i = 1'b1;
    cyc(5);
    a0 = acc_cnt;
    pulse_start(2);
    dreq_i = 1'b0;
    any_dack = 1'b0;
    for (int i = 0; i < 10; i++) begin cyc(1); if (dack_o) any_dack = 1'b1; end
    check(!any_dack, "R3 falling edge in rising mode", int'(any_dack), 0);
    dreq_i = 1'b1;
    wait_dack(seen);
    check(seen, "R3 rising edge serviced", int'(seen), 1);
    if (seen) respond(1'b0);
    dreq_i = 1'b0;
    cyc(6);
    check(acc_cnt - a0 == 1, "R3 one access per edge", acc_cnt - a0, 1);

    // R4: second edge while pending is dropped
    do_reset();
    level_mode_i = 1'b0; rise_edge_i = 1'b1; dreq_i = 1'b0;
    cyc(5);
    a0 = acc_cnt; d0 = done_cnt;
    pulse_start(3);
    dreq_i = 1'b1; cyc(2);
    dreq_i = 1'b0; cyc(2);
    dreq_i = 1'b1; cyc(2);
    dreq_i = 1'b0;
    wait_dack(seen);
    if (seen) respond(1'b0);
    cyc(12);
    check(acc_cnt - a0 == 1, "R4 edges while pending", acc_cnt - a0, 1);
    check(done_cnt - d0 == 0, "R4 no done", done_cnt - d0, 0);

    // R10: start while armed is ignored (count 1 is not reloaded)
    pulse_start(1);
    dreq_i = 1'b1;
    wait_dack(seen);
    if (seen) respond(1'b0);
    dreq_i = 1'b0; cyc(6);
    check(done_cnt - d0 == 0, "R10 start ignored when busy", done_cnt - d0, 0);

    // R7: error wins over simultaneous ack
    do_reset();
    level_mode_i = 1'b1; dreq_i = 1'b1;
    cyc(5);
    a0 = acc_cnt; d0 = done_cnt;
    pulse_start(4);
    wait_dack(seen);
    cyc(1);
    bus_err_i = 1'b1; bus_ack_i = 1'b1;
    cyc(1);
    bus_err_i = 1'b0; bus_ack_i = 1'b0;
    cyc(8);
    dreq_i = 1'b0;
    check(acc_cnt - a0 == 1, "R7 err+ack stops transfer", acc_cnt - a0, 1);
    check(done_cnt - d0 == 1, "R7 done on error", done_cnt - d0, 1);

    // R9: zero count
    do_reset();
    level_mode_i = 1'b1; dreq_i = 1'b1;
    cyc(5);
    a0 = acc_cnt; d0 = done_cnt;
    pulse_start(0);
    check(done_o == 1'b1, "R9 done the cycle after start", int'(done_o), 1);
    cyc(8);
    dreq_i = 1'b0;
    check(acc_cnt - a0 == 0, "R9 no access", acc_cnt - a0, 0);
    check(done_cnt - d0 == 1, "R9 single done", done_cnt - d0, 1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule